// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Error Detection

This block turns an oversampled asynchronous serial line into characters. It accepts 5 to 8 data bits, least significant bit first. Parity is optional and can be odd, even or stuck at a fixed value, and the incoming line can be inverted before decoding. Each character leaves on a valid/ready stream together with its parity-error and framing-error status. Separate one-cycle pulses report parity errors, framing errors and a break, which is a line held low for longer than one full configured word. A receive-timeout level tells the surrounding storage that unread data has been waiting while both the line and the storage stayed quiet.

The block counts a sample tick supplied from outside. The number of ticks per bit is 16, or the programmed divider value plus one when the alternative divider is selected. The receiver has no way to stall the serial line. Back-pressure works as follows. `m_valid` stays high and `m_data`, `m_perr` and `m_ferr` stay stable until a cycle where `m_ready` is high. A character that completes while a previous one is still waiting is discarded, but its error pulses are still raised.

Top module: `uart_rx_line`

## Requirements
- R1: Data bits are taken LSB first. `cfg_wlen` encodes the word length as 00=5, 01=6, 10=7 and 11=8 bits, and data bits above the word length read as 0 in `m_data`.
- R2: With `cfg_par_en`=1 and `cfg_par_stick`=0, the bit after the last data bit is parity. With `cfg_par_even`=1 the data and parity bits together must hold an even number of ones; with 0 they must hold an odd number. A mismatch sets `m_perr` and pulses `err_parity`.
- R3: With `cfg_par_en`=1 and `cfg_par_stick`=1, the expected parity bit is 1 when `cfg_par_even`=0 and 0 when `cfg_par_even`=1.
- R4: A stop bit that samples as 0 sets `m_ferr` and pulses `err_frame`. After this, no new start bit is accepted until the line has read 1.
- R5: A falling edge starts a character only if the line still reads 0 half a bit later. A shorter low glitch produces no character.
- R6: The bit period is 16 ticks when `cfg_os_alt`=0, and `cfg_os_div`+1 ticks when `cfg_os_alt`=1 (divider of at least 8).
- R7: With `cfg_rx_inv`=1, the level on `rx_pin` is inverted before all decoding.
- R8: `err_break` pulses once when the decoded line has stayed 0 for more than (1 + data bits + parity bit + 1) bit periods. It does not pulse again until the line has returned to 1. A character whose low run is shorter gives no pulse.
- R9: `m_valid` holds with stable `m_data` until it is accepted with `m_ready`. A character that completes while one is still waiting is dropped.
- R10: `rx_timeout` rises once `cfg_tmo_en`=1, `fifo_nonempty`=1, the receiver is idle with the line high, no `fifo_access` occurs, and this has lasted `cfg_tmo_limit` ticks. A `fifo_access` pulse or `fifo_nonempty`=0 clears it.
- R11: After reset, `m_valid`, `rx_timeout` and all error pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Serial receive line |
| os_tick | input | 1 | Oversample tick enable |
| cfg_wlen | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even-parity select |
| cfg_par_stick | input | 1 | Stick-parity select |
| cfg_rx_inv | input | 1 | Invert receive line |
| cfg_os_alt | input | 1 | Use programmed divider instead of 16 |
| cfg_os_div | input | DIV_W (4) | Programmed divider minus one |
| cfg_tmo_en | input | 1 | Timeout counter enable |
| cfg_tmo_limit | input | TMO_W (8) | Timeout length in ticks |
| fifo_nonempty | input | 1 | Downstream storage holds data |
| fifo_access | input | 1 | Downstream storage push or pop this cycle |
| m_valid | output | 1 | Character available |
| m_ready | input | 1 | Character accepted |
| m_data | output | 8 | Received data |
| m_perr | output | 1 | Parity error of held character |
| m_ferr | output | 1 | Framing error of held character |
| err_parity | output | 1 | Parity-error pulse |
| err_frame | output | 1 | Framing-error pulse |
| err_break | output | 1 | Break pulse |
| rx_timeout | output | 1 | Receive timeout level |

## Verification
The hardest state to reach from the ports is a break: the line has to stay low through a whole frame and beyond. The bench holds `rx_pin` low well past the configured word time and checks three things. It expects exactly one break pulse. It expects the all-zero character that comes with it to carry a framing error. It checks that the receiver waits for the line to go high before it can decode anything again. The bench also sends a full all-zero character with a good stop bit, to show that a low run just short of the word time gives no break. Back-pressure is reached by holding `m_ready` low across two complete characters.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLDOFF
  } rx_state_e;

  // number of data bits for a word-length code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic line
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], pin};
  end

  assign line = sh[STAGES-1] ^ inv;
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int OS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic [OS_W-1:0] os_factor,
  input  logic [1:0]      wlen,
  input  logic            par_en,
  output logic            done,
  output logic [7:0]      data,
  output logic            par_bit,
  output logic            stop_bit,
  output logic            busy
);
  localparam logic [OS_W-1:0] ONE = OS_W'(1);

  rx_state_e       st;
  logic [OS_W-1:0] cnt;
  logic [2:0]      idx;
  logic [2:0]      last_idx;
  logic [OS_W-1:0] half_m1;
  logic [OS_W-1:0] full_m1;

  assign last_idx = {1'b0, wlen} + 3'd4;
  assign half_m1  = (os_factor >> 1) - ONE;
  assign full_m1  = os_factor - ONE;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      data     <= '0;
      par_bit  <= 1'b0;
      stop_bit <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == half_m1) begin
              cnt <= '0;
              if (!line) begin
                st      <= ST_DATA;
                idx     <= '0;
                data    <= '0;
                par_bit <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_DATA: begin
            if (cnt == full_m1) begin
              cnt       <= '0;
              data[idx] <= line;
              if (idx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
              else                  idx <= idx + 3'd1;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_PAR: begin
            if (cnt == full_m1) begin
              cnt     <= '0;
              par_bit <= line;
              st      <= ST_STOP;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_STOP: begin
            if (cnt == full_m1) begin
              cnt      <= '0;
              stop_bit <= line;
              done     <= 1'b1;
              st       <= line ? ST_IDLE : ST_HOLDOFF;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_HOLDOFF: begin
            if (line) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // a start must never be taken straight out of the post-error holdoff
  AST_HOLDOFF_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLDOFF && !line) |=> (st == ST_HOLDOFF)); // R4
endmodule

// File: rtl/rx_break_watch.sv
module rx_break_watch #(
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [BW-1:0] limit,
  output logic          brk_p
);
  logic [BW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      brk_p <= 1'b0;
    end else begin
      brk_p <= 1'b0;
      if (line) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (cnt == limit) begin
          brk_p <= 1'b1;
          fired <= 1'b1;
        end else begin
          cnt <= cnt + BW'(1);
        end
      end
    end
  end

  AST_BREAK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_p |=> !brk_p); // R8
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          fifo_nonempty,
  input  logic          fifo_access,
  input  logic          rx_quiet,
  input  logic [TW-1:0] limit,
  output logic          tmo
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign armed = enable && fifo_nonempty && !fifo_access && rx_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else begin
      if (!armed)                     cnt <= '0;
      else if (tick && cnt != limit)  cnt <= cnt + TW'(1);

      if (!enable || !fifo_nonempty || fifo_access) tmo <= 1'b0;
      else if (armed && cnt == limit)               tmo <= 1'b1;
    end
  end

  AST_TMO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |=> !tmo); // R10
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
  import uart_rx_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int TMO_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pin,
  input  logic             os_tick,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic             cfg_par_stick,
  input  logic             cfg_rx_inv,
  input  logic             cfg_os_alt,
  input  logic [DIV_W-1:0] cfg_os_div,
  input  logic             cfg_tmo_en,
  input  logic [TMO_W-1:0] cfg_tmo_limit,
  input  logic             fifo_nonempty,
  input  logic             fifo_access,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_perr,
  output logic             m_ferr,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_break,
  output logic             rx_timeout
);
  localparam int OS_W  = DIV_W + 1;
  localparam int BRK_W = OS_W + 4;

  logic            line_q;
  logic [OS_W-1:0] os_factor;
  logic            f_done;
  logic [7:0]      f_data;
  logic            f_par;
  logic            f_stop;
  logic            f_busy;
  logic [3:0]      frame_bits;
  logic [BRK_W-1:0] brk_limit;
  logic            ones_odd;
  logic            perr_now;
  logic            ferr_now;

  assign os_factor  = cfg_os_alt ? (OS_W'(cfg_os_div) + OS_W'(1)) : OS_W'(16);
  assign frame_bits = data_bits(cfg_wlen) + {3'b000, cfg_par_en} + 4'd2;
  assign brk_limit  = BRK_W'(os_factor) * BRK_W'(frame_bits);

  rx_line_front #(.STAGES(SYNC_N)) u_front (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (rx_pin),
    .inv  (cfg_rx_inv),
    .line (line_q)
  );

  rx_frame_engine #(.OS_W(OS_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .line     (line_q),
    .os_factor(os_factor),
    .wlen     (cfg_wlen),
    .par_en   (cfg_par_en),
    .done     (f_done),
    .data     (f_data),
    .par_bit  (f_par),
    .stop_bit (f_stop),
    .busy     (f_busy)
  );

  rx_break_watch #(.BW(BRK_W)) u_break (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (os_tick),
    .line (line_q),
    .limit(brk_limit),
    .brk_p(err_break)
  );

  rx_idle_timer #(.TW(TMO_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (os_tick),
    .enable       (cfg_tmo_en),
    .fifo_nonempty(fifo_nonempty),
    .fifo_access  (fifo_access),
    .rx_quiet     (!f_busy && line_q),
    .limit        (cfg_tmo_limit),
    .tmo          (rx_timeout)
  );

  // parity and stop checks on the completed character
  assign ones_odd = ^{f_data, f_par};
  always_comb begin
    if (!cfg_par_en)        perr_now = 1'b0;
    else if (cfg_par_stick) perr_now = (f_par == cfg_par_even);
    else if (cfg_par_even)  perr_now = ones_odd;
    else                    perr_now = !ones_odd;
  end
  assign ferr_now = !f_stop;

  // output holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid    <= 1'b0;
      m_data     <= '0;
      m_perr     <= 1'b0;
      m_ferr     <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
    end else begin
      err_parity <= f_done && perr_now;
      err_frame  <= f_done && ferr_now;
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (f_done && (!m_valid || m_ready)) begin
        m_valid <= 1'b1;
        m_data  <= f_data;
        m_perr  <= perr_now;
        m_ferr  <= ferr_now;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_perr))); // R9
  AST_PERR_NEEDS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> cfg_par_en); // R2
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> !$past(line_q)); // R8
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> !err_frame); // R4
endmodule

// File: tb/tb_uart_rx_line.sv
module tb_uart_rx_line;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pin = 1'b1;
  logic os_tick = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0, cfg_rx_inv = 1'b0;
  logic cfg_os_alt = 1'b0;
  logic [3:0] cfg_os_div = 4'd0;
  logic cfg_tmo_en = 1'b0;
  logic [7:0] cfg_tmo_limit = 8'd50;
  logic fifo_nonempty = 1'b0, fifo_access = 1'b0;
  logic m_valid, m_ready = 1'b1;
  logic [7:0] m_data;
  logic m_perr, m_ferr, err_parity, err_frame, err_break, rx_timeout;

  int errors = 0, checks = 0;
  int got_cnt = 0, brk_cnt = 0, pe_cnt = 0, fe_cnt = 0;
  logic [7:0] last_data = '0;
  logic last_perr = 1'b0, last_ferr = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_line dut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .os_tick(os_tick),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_rx_inv(cfg_rx_inv), .cfg_os_alt(cfg_os_alt),
    .cfg_os_div(cfg_os_div), .cfg_tmo_en(cfg_tmo_en), .cfg_tmo_limit(cfg_tmo_limit),
    .fifo_nonempty(fifo_nonempty), .fifo_access(fifo_access), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_perr(m_perr), .m_ferr(m_ferr),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .rx_timeout(rx_timeout)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready) begin
        got_cnt++;
        last_data = m_data;
        last_perr = m_perr;
        last_ferr = m_ferr;
      end
      if (err_break)  brk_cnt++;
      if (err_parity) pe_cnt++;
      if (err_frame)  fe_cnt++;
    end
  end

  typedef struct packed {
    logic [1:0] wl;
    logic pen, ev, st, inv;
    logic [7:0] d;
    logic pb, sb;
    logic [7:0] ed;
    logic ep, ef;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07, 1'b1, 1'b1, 8'h07, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b1, 8'h2A, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 5:       return "R1";
      1, 2, 3, 4: return "R2";
      6, 7:       return "R3";
      8:          return "R4";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one frame, levels xor'ed with the current inversion setting
  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit pb, input bit sb, input int fac);
    rx_pin = cfg_rx_inv ^ 1'b0;
    idle(fac);
    for (int b = 0; b < nb; b++) begin
      rx_pin = cfg_rx_inv ^ d[b];
      idle(fac);
    end
    if (pen) begin
      rx_pin = cfg_rx_inv ^ pb;
      idle(fac);
    end
    rx_pin = cfg_rx_inv ^ sb;
    idle(fac);
    rx_pin = cfg_rx_inv ^ 1'b1;
    idle(2 * fac);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g0, b0, p0, f0;
    idle(3);
    // R11 reset state
    check(m_valid == 1'b0, "R11", "m_valid in reset", m_valid, 0);
    rst_n = 1'b1;
    idle(5);
    check(m_valid == 1'b0 && rx_timeout == 1'b0, "R11", "valid/timeout after reset",
          {m_valid, rx_timeout}, 0);
    check({err_parity, err_frame, err_break} == 3'b000, "R11", "error pulses after reset",
          {err_parity, err_frame, err_break}, 0);

    // table of frames
    for (int i = 0; i < NV; i++) begin
      cfg_wlen = VT[i].wl; cfg_par_en = VT[i].pen; cfg_par_even = VT[i].ev;
      cfg_par_stick = VT[i].st; cfg_rx_inv = VT[i].inv; rx_pin = VT[i].inv ^ 1'b1;
      idle(40);
      g0 = got_cnt; p0 = pe_cnt; f0 = fe_cnt;
      send_frame(VT[i].d, 5 + int'(VT[i].wl), VT[i].pen, VT[i].pb, VT[i].sb, 16);
      idle(20);
      check(got_cnt == g0 + 1, req_of(i), $sformatf("vec%0d count", i), got_cnt - g0, 1);
      check(last_data == VT[i].ed, req_of(i), $sformatf("vec%0d data", i), last_data, VT[i].ed);
      check(last_perr == VT[i].ep && (pe_cnt - p0) == int'(VT[i].ep), req_of(i),
            $sformatf("vec%0d parity flag", i), last_perr, VT[i].ep);
      check(last_ferr == VT[i].ef && (fe_cnt - f0) == int'(VT[i].ef), req_of(i),
            $sformatf("vec%0d frame flag", i), last_ferr, VT[i].ef);
    end
    cfg_rx_inv = 1'b0; rx_pin = 1'b1; cfg_wlen = 2'd3;
    cfg_par_en = 1'b0; cfg_par_stick = 1'b0; cfg_par_even = 1'b0;
    idle(40);

    // R5 short glitch rejected, real frame afterwards still decoded
    g0 = got_cnt;
    rx_pin = 1'b0; idle(4); rx_pin = 1'b1; idle(300);
    check(got_cnt == g0, "R5", "glitch produced character", got_cnt - g0, 0);
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, 16); idle(20);
    check(got_cnt == g0 + 1 && last_data == 8'h5A, "R5", "frame after glitch", last_data, 8'h5A);

    // R6 alternative divider: 10 ticks per bit
    cfg_os_alt = 1'b1; cfg_os_div = 4'd9; idle(40);
    g0 = got_cnt;
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, 10); idle(20);
    check(got_cnt == g0 + 1 && last_data == 8'hC3, "R6", "divider 10 frame", last_data, 8'hC3);
    cfg_os_alt = 1'b0; idle(40);

    // R8 all-zero character with good stop: low run below word time
    b0 = brk_cnt; g0 = got_cnt;
    send_frame(8'h00, 8, 1'b0, 1'b0, 1'b1, 16); idle(20);
    check(brk_cnt == b0, "R8", "no break on normal zero frame", brk_cnt - b0, 0);
    check(last_data == 8'h00 && last_ferr == 1'b0, "R8", "zero frame data", last_ferr, 0);

    // R8 and R4: true break
    b0 = brk_cnt; g0 = got_cnt; f0 = fe_cnt;
    rx_pin = 1'b0; idle(400);
    check(brk_cnt == b0 + 1, "R8", "single break pulse", brk_cnt - b0, 1);
    check(got_cnt == g0 + 1 && last_ferr == 1'b1, "R4", "break char framing error", last_ferr, 1);
    check(fe_cnt == f0 + 1, "R4", "no restart while line low", fe_cnt - f0, 1);
    rx_pin = 1'b1; idle(40);
    send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1, 16); idle(20);
    check(last_data == 8'h96 && got_cnt == g0 + 2, "R4", "decode after holdoff", last_data, 8'h96);

    // R9 back-pressure
    m_ready = 1'b0;
    g0 = got_cnt;
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 16);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1, 16);
    idle(10);
    check(m_valid == 1'b1 && m_data == 8'h11, "R9", "held first character", m_data, 8'h11);
    m_ready = 1'b1;
    idle(3);
    check(got_cnt == g0 + 1 && last_data == 8'h11 && m_valid == 1'b0, "R9",
          "second character dropped", got_cnt - g0, 1);

    // R10 receive timeout
    cfg_tmo_en = 1'b1; cfg_tmo_limit = 8'd50; fifo_nonempty = 1'b1;
    idle(40);
    check(rx_timeout == 1'b0, "R10", "timeout before limit", rx_timeout, 0);
    idle(40);
    check(rx_timeout == 1'b1, "R10", "timeout after limit", rx_timeout, 1);
    fifo_access = 1'b1; idle(1); fifo_access = 1'b0; idle(1);
    check(rx_timeout == 1'b0, "R10", "cleared by access", rx_timeout, 0);
    idle(80);
    check(rx_timeout == 1'b1, "R10", "re-armed after access", rx_timeout, 1);
    fifo_nonempty = 1'b0; idle(2);
    check(rx_timeout == 1'b0, "R10", "cleared when empty", rx_timeout, 0);
    idle(100);
    check(rx_timeout == 1'b0, "R10", "no timeout when empty", rx_timeout, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule